// File: doc/BRIEF.md
# Two-wire serial clock generator

This block produces the serial clock for the master side of a two-wire (I2C-style) bus. It uses a two-stage time base. A 7-bit prescale value first divides the system clock down to a reference tick, which software normally sets near 10 MHz. Two 8-bit counts then give the length of the low and the high half of each serial clock period, both counted in reference ticks.

A bit-level engine connects to the strobes. `mid_low_o` marks the point in the low half where SDA may change. `low_end_o` marks the last low tick, after which the line is released and SDA is sampled. `high_end_o` closes the period. The high half counts only while the sensed SCL line is actually high, so a slave that holds SCL low stretches the clock. One enable input gates the whole generator.

Software derives each count from the target rate R in kHz as ((10000 / R) + 1) / 2. This gives 50 for 100 kHz and 250 for 20 kHz, and both fit the 8-bit fields.

Top module: `twi_sclk_gen`

## Requirements
- R1: With enable set, `ref_tick_o` pulses for one cycle once every max(P,1) system clocks, where P is `prescale_i`. A prescale of 0 therefore ticks on every cycle.
- R2: `divider_i[15:8]` holds the high count H and `divider_i[7:0]` holds the low count L. With no stretching, `scl_low_o` stays 1 for exactly P*L cycles and 0 for exactly P*H cycles of every period (P taken as max(P,1)).
- R3: A low or high count of 0 behaves as a count of 1.
- R4: While `enable_i` is 0, `scl_low_o`, `ref_tick_o` and all strobes are 0 in that same cycle, and the prescale and phase counters return to zero. The first low half after re-enable lasts a full P*L cycles.
- R5: During the high half, a reference tick that arrives while `scl_sense_i` is 0 is not counted. With P=1, N stretched cycles lengthen the high half to H+N cycles, and `high_end_o` never fires while `scl_sense_i` is 0.
- R6: `mid_low_o` is a one-cycle pulse, once per low half, on the reference tick at which floor(L/2) low ticks have already elapsed. This is cycle P*(floor(L/2)+1) of the low half.
- R7: `low_end_o` is a one-cycle pulse on the final low tick, in the last cycle of the low half, and `scl_low_o` is 0 in the following cycle.
- R8: `high_end_o` is a one-cycle pulse on the final counted high tick, in the last cycle of the high half. `scl_low_o` is 1 in the following cycle while still enabled, and `high_end_o` and `low_end_o` never coincide.
- R9: After reset with enable clear, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Global enable; when clear, no clock is generated |
| prescale_i | input | 7 | System clocks per reference tick (0 acts as 1) |
| divider_i | input | 16 | [15:8] high count, [7:0] low count, in reference ticks |
| scl_sense_i | input | 1 | Sampled level of the SCL line |
| ref_tick_o | output | 1 | One-cycle reference tick |
| scl_low_o | output | 1 | 1 = pull SCL low, 0 = release |
| mid_low_o | output | 1 | Strobe at mid low half (SDA change point) |
| low_end_o | output | 1 | Strobe on the last low tick (SDA sample follows) |
| high_end_o | output | 1 | Strobe on the last high tick |

## Verification
The bench builds the block with its default widths: a 7-bit prescale and 8-bit phase counts. Prescale values 0, 1, 2, 3, 10 and 127 are driven at run time. These cover the zero-as-one rule, the full 7-bit range, and the nominal 100 kHz setting of 50/50 ticks at a prescale of 10. Counts of 250 at a prescale of 2 exercise the slowest supported rate in the 8-bit fields. Stretching is tested at a prescale of 1, where each held cycle removes exactly one tick, so the lengthened high half has an exact expected length.

// File: rtl/twi_clk_pkg.sv
package twi_clk_pkg;
  typedef enum logic {
    PH_LOW  = 1'b0,
    PH_HIGH = 1'b1
  } scl_phase_e;
endpackage

// File: rtl/twi_prescaler.sv
module twi_prescaler #(
  parameter int PRE_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [PRE_W-1:0] div_i,
  output logic             tick_o
);
  logic [PRE_W-1:0] cnt_q;
  logic [PRE_W-1:0] last;

  // zero divides as one
  always_comb last = (div_i == '0) ? '0 : div_i - 1'b1;
  // >= keeps a lowered divider from skipping a wrap
  always_comb tick_o = en_i && (cnt_q >= last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (!en_i || tick_o) cnt_q <= '0;
    else                      cnt_q <= cnt_q + 1'b1;
  end

  assert_tick_spacing_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && div_i > 1) |=> (!tick_o || div_i != $past(div_i)));

  assert_pre_cleared_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (cnt_q == '0));
endmodule

// File: rtl/twi_phase_timer.sv
module twi_phase_timer
  import twi_clk_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] low_cnt_i,
  input  logic [CNT_W-1:0] high_cnt_i,
  input  logic             scl_sense_i,
  output logic             scl_low_o,
  output logic             mid_low_o,
  output logic             low_end_o,
  output logic             high_end_o
);
  scl_phase_e       phase_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] low_last, high_last, low_half;
  logic             low_tick, high_tick;

  always_comb begin
    low_last  = (low_cnt_i  == '0) ? '0 : low_cnt_i  - 1'b1;
    high_last = (high_cnt_i == '0) ? '0 : high_cnt_i - 1'b1;
    low_half  = low_cnt_i >> 1;
    low_tick  = en_i && tick_i && (phase_q == PH_LOW);
    // high half only advances once the line is really high
    high_tick = en_i && tick_i && (phase_q == PH_HIGH) && scl_sense_i;
    mid_low_o  = low_tick && (cnt_q == low_half);
    low_end_o  = low_tick && (cnt_q >= low_last);
    high_end_o = high_tick && (cnt_q >= high_last);
    scl_low_o  = en_i && (phase_q == PH_LOW);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_LOW;
      cnt_q   <= '0;
    end else if (!en_i) begin
      phase_q <= PH_LOW;
      cnt_q   <= '0;
    end else if (low_end_o) begin
      phase_q <= PH_HIGH;
      cnt_q   <= '0;
    end else if (high_end_o) begin
      phase_q <= PH_LOW;
      cnt_q   <= '0;
    end else if (low_tick || high_tick) begin
      cnt_q   <= cnt_q + 1'b1;
    end
  end

  assert_cnt_cleared_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (phase_q == PH_LOW && cnt_q == '0));

  assert_stretch_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && phase_q == PH_HIGH && !scl_sense_i) |=> (cnt_q == $past(cnt_q) || !en_i));

  assert_low_end_release_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    low_end_o |=> !scl_low_o);

  assert_high_end_pull_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    high_end_o |=> (scl_low_o || !en_i));

  assert_strobe_excl_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({low_end_o, high_end_o}));
endmodule

// File: rtl/twi_sclk_gen.sv
module twi_sclk_gen #(
  parameter int PRE_W = 7,
  parameter int CNT_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               enable_i,
  input  logic [PRE_W-1:0]   prescale_i,
  input  logic [2*CNT_W-1:0] divider_i,
  input  logic               scl_sense_i,
  output logic               ref_tick_o,
  output logic               scl_low_o,
  output logic               mid_low_o,
  output logic               low_end_o,
  output logic               high_end_o
);
  localparam int DIV_W = 2 * CNT_W;

  logic [CNT_W-1:0] high_cnt, low_cnt;
  assign high_cnt = divider_i[DIV_W-1:CNT_W];
  assign low_cnt  = divider_i[CNT_W-1:0];

  twi_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (enable_i),
    .div_i  (prescale_i),
    .tick_o (ref_tick_o)
  );

  twi_phase_timer #(.CNT_W(CNT_W)) u_phase (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (enable_i),
    .tick_i      (ref_tick_o),
    .low_cnt_i   (low_cnt),
    .high_cnt_i  (high_cnt),
    .scl_sense_i (scl_sense_i),
    .scl_low_o   (scl_low_o),
    .mid_low_o   (mid_low_o),
    .low_end_o   (low_end_o),
    .high_end_o  (high_end_o)
  );

  assert_released_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |-> !(scl_low_o || ref_tick_o || mid_low_o || low_end_o || high_end_o));
endmodule

// File: tb/twi_sclk_gen_bench.sv
`timescale 1ns/1ps
module twi_sclk_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic [6:0]  prescale = '0;
  logic [15:0] divider = '0;
  logic        stretch = 1'b0;
  logic        scl_sense;
  logic        ref_tick, scl_low, mid_low, low_end, high_end;
  int          n_chk = 0;
  int          n_fail = 0;

  always #4 clk = ~clk;

  // open-drain line: low when master pulls or slave stretches
  assign scl_sense = !scl_low && !stretch;

  twi_sclk_gen u_twi_sclk_gen (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .enable_i    (enable),
    .prescale_i  (prescale),
    .divider_i   (divider),
    .scl_sense_i (scl_sense),
    .ref_tick_o  (ref_tick),
    .scl_low_o   (scl_low),
    .mid_low_o   (mid_low),
    .low_end_o   (low_end),
    .high_end_o  (high_end)
  );

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic setup(input int p, input int h, input int l);
    @(negedge clk);
    enable   = 1'b0;
    prescale = 7'(p);
    divider  = {8'(h), 8'(l)};
    @(negedge clk);
    enable = 1'b1;
  endtask

  // measures one full period starting at a rising scl_low
  task automatic measure(input int sn, output int ll, output int hl,
                         output int mid_pos, output int mid_n,
                         output int le_pos, output int le_n,
                         output int he_pos, output int he_n);
    bit prev;
    prev = scl_low;
    forever begin
      @(negedge clk);
      if (scl_low && !prev) break;
      prev = scl_low;
    end
    ll = 0; mid_n = 0; le_n = 0; he_n = 0; hl = 0;
    mid_pos = 0; le_pos = 0; he_pos = 0;
    do begin
      ll++;
      if (mid_low) begin mid_pos = ll; mid_n++; end
      if (low_end) begin le_pos = ll; le_n++; end
      @(negedge clk);
    end while (scl_low);
    do begin
      hl++;
      stretch = (hl <= sn);
      #1;
      if (high_end) begin he_pos = hl; he_n++; end
      @(negedge clk);
    end while (!scl_low);
    stretch = 1'b0;
  endtask

  task automatic period_test(input int p, input int h, input int l, input int sn);
    int ll, hl, mp, mn, lp, ln, hp, hn, pe, he, le;
    pe = (p == 0) ? 1 : p;
    he = (h == 0) ? 1 : h;
    le = (l == 0) ? 1 : l;
    setup(p, h, l);
    measure(0, ll, hl, mp, mn, lp, ln, hp, hn); // skip first period
    measure(sn, ll, hl, mp, mn, lp, ln, hp, hn);
    chk(ll == pe*le, (h == 0 || l == 0) ? "R3 low length" : "R2 low length", ll, pe*le);
    chk(hl == pe*he + sn, (sn > 0) ? "R5 stretched high length" : "R2 high length", hl, pe*he + sn);
    chk(mn == 1 && mp == pe*(le/2 + 1), "R6 mid_low position", mp, pe*(le/2 + 1));
    chk(ln == 1 && lp == ll, "R7 low_end position", lp, ll);
    chk(hn == 1 && hp == hl, "R8 high_end position", hp, hl);
  endtask

  task automatic tick_gap_test(input int p);
    int gap, exp;
    exp = (p == 0) ? 1 : p;
    setup(p, 4, 4);
    do @(negedge clk); while (!ref_tick);
    gap = 0;
    do begin @(negedge clk); gap++; end while (!ref_tick);
    chk(gap == exp, "R1 tick spacing", gap, exp);
    gap = 0;
    do begin @(negedge clk); gap++; end while (!ref_tick);
    chk(gap == exp, "R1 tick spacing repeat", gap, exp);
  endtask

  task automatic reset_test();
    chk({ref_tick, scl_low, mid_low, low_end, high_end} == 5'b0, "R9 reset outputs",
        {ref_tick, scl_low, mid_low, low_end, high_end}, 0);
  endtask

  task automatic disable_test();
    int act, ll;
    setup(2, 3, 5);
    repeat (23) @(negedge clk);
    do @(negedge clk); while (!scl_low);
    repeat (3) @(negedge clk);
    enable = 1'b0;
    #1;
    chk(!scl_low, "R4 scl released on disable", scl_low, 0);
    act = 0;
    repeat (20) begin
      @(negedge clk);
      act += int'(ref_tick) + int'(scl_low) + int'(mid_low) + int'(low_end) + int'(high_end);
    end
    chk(act == 0, "R4 no activity while disabled", act, 0);
    enable = 1'b1;
    #1;
    chk(scl_low, "R4 low half starts on enable", scl_low, 1);
    ll = 0;
    do begin ll++; @(negedge clk); end while (scl_low);
    chk(ll == 10, "R4 fresh low half after re-enable", ll, 10);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog R1..R9 actual=hung expected=complete");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    reset_test();
    tick_gap_test(0);
    tick_gap_test(1);
    tick_gap_test(3);
    tick_gap_test(127);
    period_test(1, 5, 3, 0);
    period_test(3, 4, 2, 0);
    period_test(0, 2, 6, 0);
    period_test(10, 50, 50, 0);
    period_test(2, 250, 250, 0);
    period_test(1, 0, 0, 0);
    period_test(2, 3, 0, 0);
    period_test(1, 6, 4, 7);
    period_test(1, 1, 1, 2);
    disable_test();
    summary();
    $finish;
  end
endmodule